// File: doc/BRIEF.md
# Inter-Task Message Broadcast Hub

This block is an on-chip publish/subscribe hub that serves several software tasks. Each task owns one port made of a single-entry transmit mailbox and a small receive store. A task publishes by writing an 8-bit identifier and a 32-bit payload word into its mailbox. The identifier doubles as the priority. The payload can stand alone as a short status value. No checksum is added or checked.

Pending mailboxes compete for one internal broadcast bus, and the lowest-numbered port wins. The winning message is compared against every other port's identifier filter and mask in the same cycle, and it is written into all accepting receive stores on one clock edge.

Each receive store is a set of parallel slots and not a queue. A read always returns the stored message with the smallest identifier. When a store is full, a per-port policy decides what happens: either the arriving message is discarded, or it replaces the weakest stored message when it outranks it. Sticky per-port flags report stored messages and lost messages, and writing one to a flag clears it.

Top module: `msg_hub`

## Requirements
- R1: A port accepts a bus message when (id AND mask) equals (filter AND mask), using its `cfg_filter` and `cfg_mask` bytes. A mask of 0x00 accepts every identifier, and a mask of 0xFF accepts exactly one identifier.
- R2: One published message, with identifier and payload unchanged, lands in every accepting port on the same clock edge. A message written at edge k is loaded into the mailbox at edge k+1 and stored at edge k+2 when it wins the bus.
- R3: A port never stores a message that it published itself, even when its own filter would accept it.
- R4: `rx_valid`, `rx_id` and `rx_data` present the stored message with the numerically lowest identifier. A one-cycle `rx_rd` pulse while `rx_valid` is high removes that message.
- R5: With `cfg_ovw` = 0 and every slot occupied, an accepted message is discarded, the stored messages are left untouched, and `st_drop` is set.
- R6: With `cfg_ovw` = 1 and every slot occupied, an accepted message replaces the stored message with the highest identifier only if its own identifier is lower. Otherwise it is discarded. In both cases `st_drop` is set.
- R7: Among pending mailboxes, the lowest port index wins the bus. The others stay pending (`tx_pending` high) and go out on later cycles in index order. A `tx_wr` to a pending mailbox is ignored.
- R8: `st_avail` is set on every store into a port and `st_drop` on every lost message. Both hold until a one is written to `st_clr_avail` or `st_clr_drop` for that port, and only that port's bit is cleared. A new event in the same cycle wins over the clear.
- R9: When a read and an accepted arrival hit a full store on the same edge, the slot freed by the read takes the new message, and nothing is lost.
- R10: After reset, no mailbox is pending, no receive slot is valid, and all status flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr | input | NPORTS | Per-port publish strobe |
| tx_id | input | 8*NPORTS | Identifier for each port's publish |
| tx_data | input | 32*NPORTS | Payload for each port's publish |
| tx_pending | output | NPORTS | Mailbox holds a message not yet broadcast |
| cfg_filter | input | 8*NPORTS | Acceptance filter byte per port |
| cfg_mask | input | 8*NPORTS | Acceptance mask byte per port |
| cfg_ovw | input | NPORTS | Full policy: 1 overwrite, 0 drop |
| rx_rd | input | NPORTS | Remove the presented message |
| rx_valid | output | NPORTS | A stored message is presented |
| rx_id | output | 8*NPORTS | Identifier of the presented message |
| rx_data | output | 32*NPORTS | Payload of the presented message |
| st_clr_avail | input | NPORTS | Write-one-to-clear for st_avail |
| st_clr_drop | input | NPORTS | Write-one-to-clear for st_drop |
| st_avail | output | NPORTS | Sticky: a message was stored |
| st_drop | output | NPORTS | Sticky: a message was lost |

## Verification
The hardest case to reach from the ports is a read and an arrival landing on a full store on the same edge (R9). The bench fills a store, writes a mailbox, and raises `rx_rd` exactly one cycle later. That cycle is the edge on which the broadcast happens.

A similar timing trap lets the bench test the ignored write in R7. Three ports publish together, and one of them is written again while it is still waiting for the bus. After the drain, the second message must be absent, and the store must show the first winner's message alone after the first broadcast edge.

// File: rtl/msg_hub_pkg.sv
// Shared types for the broadcast hub: one message is an identifier and a payload.
package msg_hub_pkg;
    parameter int ID_W   = 8;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } msg_t;
endpackage

// File: rtl/msg_hub_arb.sv
// Fixed-priority bus arbiter: the lowest-indexed requester is granted.
// Assumes requests are the mailbox pending flags; grant is combinational.
module msg_hub_arb #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] req,
    output logic [NPORTS-1:0] grant
);
    logic [NPORTS:0] lower_busy;

    assign lower_busy[0] = 1'b0;

    // Build a prefix OR so that each stage knows whether a lower index requests.
    for (genvar i = 0; i < NPORTS; i++) begin : g_prefix
        assign lower_busy[i+1] = lower_busy[i] | req[i];
        assign grant[i]        = req[i] & ~lower_busy[i];
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("more than one grant");

    assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0)
        else $error("grant without request");

    assert_low_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> grant[0])
        else $error("port 0 request not granted");
endmodule

// File: rtl/msg_hub_txbox.sv
// Single-entry transmit mailbox for one port.
// Accepts a write only while empty; empties on the cycle its grant is seen.
module msg_hub_txbox
    import msg_hub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  msg_t wr_msg,
    input  logic grant,
    output logic pend,
    output msg_t msg
);
    // Load on write when empty, release on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            msg  <= '0;
        end else if (grant) begin
            pend <= 1'b0;
        end else if (wr && !pend) begin
            pend <= 1'b1;
            msg  <= wr_msg;
        end
    end

    assert_pending_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !grant) |=> pend)
        else $error("pending message lost without grant");

    assert_grant_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !pend)
        else $error("mailbox not emptied after grant");
endmodule

// File: rtl/msg_hub_rxport.sv
// Receive side of one port: acceptance filter, parallel slots, full policy,
// sticky status. Presents the lowest identifier; ties go to the lowest slot.
// Assumes at most one bus message per cycle and NSLOTS >= 2.
module msg_hub_rxport
    import msg_hub_pkg::*;
#(
    parameter int NSLOTS   = 3,
    parameter int SRC_W    = 2,
    parameter int PORT_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_vld,
    input  logic [SRC_W-1:0] bus_src,
    input  msg_t             bus_msg,
    input  logic [ID_W-1:0]  cfg_filter,
    input  logic [ID_W-1:0]  cfg_mask,
    input  logic             cfg_ovw,
    input  logic             rd,
    input  logic             clr_avail,
    input  logic             clr_drop,
    output logic             head_vld,
    output msg_t             head_msg,
    output logic             st_avail,
    output logic             st_drop
);
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

    msg_t [NSLOTS-1:0] slot_q;
    logic [NSLOTS-1:0] slot_vld;
    logic [SLOT_W-1:0] head_idx, free_idx, worst_idx, tgt_idx;
    logic              head_hit, free_hit, worst_hit;
    logic [NSLOTS-1:0] pop_mask, kept;
    logic              accept, store, lost;

    // Filter: masked compare, own publications excluded.
    always_comb begin
        accept = bus_vld && (bus_src != SRC_W'(PORT_IDX)) &&
                 ((bus_msg.id & cfg_mask) == (cfg_filter & cfg_mask));
    end

    // Find the most urgent stored message (lowest identifier).
    always_comb begin
        head_idx = '0;
        head_hit = 1'b0;
        for (int s = 0; s < NSLOTS; s++) begin
            if (slot_vld[s] && (!head_hit || slot_q[s].id < slot_q[head_idx].id)) begin
                head_idx = SLOT_W'(s);
                head_hit = 1'b1;
            end
        end
    end

    // Slots still occupied after this cycle's read.
    always_comb begin
        pop_mask = (rd && head_hit) ? (NSLOTS'(1) << head_idx) : '0;
        kept     = slot_vld & ~pop_mask;
    end

    // Lowest free slot after the read.
    always_comb begin
        free_idx = '0;
        free_hit = 1'b0;
        for (int s = NSLOTS - 1; s >= 0; s--) begin
            if (!kept[s]) begin
                free_idx = SLOT_W'(s);
                free_hit = 1'b1;
            end
        end
    end

    // Weakest stored message (highest identifier), candidate for eviction.
    always_comb begin
        worst_idx = '0;
        worst_hit = 1'b0;
        for (int s = 0; s < NSLOTS; s++) begin
            if (kept[s] && (!worst_hit || slot_q[s].id >= slot_q[worst_idx].id)) begin
                worst_idx = SLOT_W'(s);
                worst_hit = 1'b1;
            end
        end
    end

    // Decide whether and where the arriving message is stored.
    always_comb begin
        store   = accept && (free_hit ||
                  (cfg_ovw && worst_hit && (bus_msg.id < slot_q[worst_idx].id)));
        lost    = accept && !free_hit;
        tgt_idx = free_hit ? free_idx : worst_idx;
    end

    // Slot state update: remove the read message, write the arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            slot_q   <= '0;
        end else begin
            slot_vld <= kept | (store ? (NSLOTS'(1) << tgt_idx) : '0);
            if (store) begin
                slot_q[tgt_idx] <= bus_msg;
            end
        end
    end

    // Sticky status flags, write-one-to-clear, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_avail <= 1'b0;
            st_drop  <= 1'b0;
        end else begin
            st_avail <= store | (st_avail & ~clr_avail);
            st_drop  <= lost  | (st_drop  & ~clr_drop);
        end
    end

    assign head_vld = head_hit;
    assign head_msg = slot_q[head_idx];

    assert_no_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_src == SRC_W'(PORT_IDX) && !rd) |=>
            ($countones(slot_vld) == $countones($past(slot_vld))))
        else $error("own message stored");

    assert_rd_pops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && head_vld && !accept) |=>
            ($countones(slot_vld) + 1 == $countones($past(slot_vld))))
        else $error("read did not remove a message");

    assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&slot_vld) && !rd && !cfg_ovw) |=> ($stable(slot_q) && $stable(slot_vld)))
        else $error("full store changed under drop policy");

    assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (&slot_vld) && !rd) |=> st_drop)
        else $error("loss not flagged");

    assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_drop && !clr_drop) |=> st_drop)
        else $error("drop flag cleared without write");

    assert_read_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd && head_vld) |=> !st_drop || $past(st_drop))
        else $error("arrival lost despite simultaneous read");
endmodule

// File: rtl/msg_hub.sv
// Broadcast hub top: per-port mailboxes, one shared bus chosen by a fixed
// priority arbiter, and per-port receive stores fed in parallel.
// Assumes NPORTS >= 2; all configuration inputs are quasi-static.
module msg_hub
    import msg_hub_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NSLOTS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        tx_wr,
    input  logic [NPORTS*ID_W-1:0]   tx_id,
    input  logic [NPORTS*DATA_W-1:0] tx_data,
    output logic [NPORTS-1:0]        tx_pending,
    input  logic [NPORTS*ID_W-1:0]   cfg_filter,
    input  logic [NPORTS*ID_W-1:0]   cfg_mask,
    input  logic [NPORTS-1:0]        cfg_ovw,
    input  logic [NPORTS-1:0]        rx_rd,
    output logic [NPORTS-1:0]        rx_valid,
    output logic [NPORTS*ID_W-1:0]   rx_id,
    output logic [NPORTS*DATA_W-1:0] rx_data,
    input  logic [NPORTS-1:0]        st_clr_avail,
    input  logic [NPORTS-1:0]        st_clr_drop,
    output logic [NPORTS-1:0]        st_avail,
    output logic [NPORTS-1:0]        st_drop
);
    localparam int SRC_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic [NPORTS-1:0] grant;
    msg_t              box_msg [NPORTS];
    msg_t              head_msg [NPORTS];
    logic              bus_vld;
    logic [SRC_W-1:0]  bus_src;
    msg_t              bus_msg;

    msg_hub_arb #(.NPORTS(NPORTS)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (tx_pending),
        .grant (grant)
    );

    // Shared bus: carry the granted mailbox and its source index.
    always_comb begin
        bus_vld = 1'b0;
        bus_src = '0;
        bus_msg = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (grant[p]) begin
                bus_vld = 1'b1;
                bus_src = SRC_W'(p);
                bus_msg = box_msg[p];
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        msg_t wr_msg;
        assign wr_msg = '{id: tx_id[p*ID_W +: ID_W], data: tx_data[p*DATA_W +: DATA_W]};

        msg_hub_txbox u_tx (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (tx_wr[p]),
            .wr_msg (wr_msg),
            .grant  (grant[p]),
            .pend   (tx_pending[p]),
            .msg    (box_msg[p])
        );

        msg_hub_rxport #(
            .NSLOTS   (NSLOTS),
            .SRC_W    (SRC_W),
            .PORT_IDX (p)
        ) u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .bus_vld    (bus_vld),
            .bus_src    (bus_src),
            .bus_msg    (bus_msg),
            .cfg_filter (cfg_filter[p*ID_W +: ID_W]),
            .cfg_mask   (cfg_mask[p*ID_W +: ID_W]),
            .cfg_ovw    (cfg_ovw[p]),
            .rd         (rx_rd[p]),
            .clr_avail  (st_clr_avail[p]),
            .clr_drop   (st_clr_drop[p]),
            .head_vld   (rx_valid[p]),
            .head_msg   (head_msg[p]),
            .st_avail   (st_avail[p]),
            .st_drop    (st_drop[p])
        );

        assign rx_id[p*ID_W +: ID_W]       = head_msg[p].id;
        assign rx_data[p*DATA_W +: DATA_W] = head_msg[p].data;
    end

    assert_one_bus_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_pending) |-> bus_vld)
        else $error("pending mailbox but idle bus");
endmodule

// File: tb/msg_hub_tb.sv
// Scoreboard bench: driver tasks publish and push expected reads, the
// monitor task pops each expectation and compares it with the port output.
module msg_hub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] tx_wr = '0;
    logic [NP*8-1:0]  tx_id = '0;
    logic [NP*32-1:0] tx_data = '0;
    logic [NP-1:0] tx_pending;
    logic [NP*8-1:0]  cfg_filter;
    logic [NP*8-1:0]  cfg_mask;
    logic [NP-1:0] cfg_ovw;
    logic [NP-1:0] rx_rd = '0;
    logic [NP-1:0] rx_valid;
    logic [NP*8-1:0]  rx_id;
    logic [NP*32-1:0] rx_data;
    logic [NP-1:0] st_clr_avail = '0;
    logic [NP-1:0] st_clr_drop = '0;
    logic [NP-1:0] st_avail;
    logic [NP-1:0] st_drop;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int          port;
        logic [7:0]  id;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Port config: p0 all/drop, p1 0x1X/drop, p2 exactly 0x25/overwrite, p3 all/overwrite.
    assign cfg_filter = {8'h00, 8'h25, 8'h10, 8'h00};
    assign cfg_mask   = {8'h00, 8'hFF, 8'hF0, 8'h00};
    assign cfg_ovw    = 4'b1100;

    msg_hub #(.NPORTS(NP), .NSLOTS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_id(tx_id), .tx_data(tx_data),
        .tx_pending(tx_pending), .cfg_filter(cfg_filter), .cfg_mask(cfg_mask),
        .cfg_ovw(cfg_ovw), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_data(rx_data), .st_clr_avail(st_clr_avail), .st_clr_drop(st_clr_drop),
        .st_avail(st_avail), .st_drop(st_drop)
    );

    function automatic logic [31:0] dat(input int src, input logic [7:0] id);
        return {16'hBEEF, src[7:0], id};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: publish one message from port src and wait until it is stored.
    task automatic publish(input int src, input logic [7:0] id);
        tx_wr[src] = 1'b1;
        tx_id[src*8 +: 8] = id;
        tx_data[src*32 +: 32] = dat(src, id);
        tick();
        tx_wr[src] = 1'b0;
        tick();
    endtask

    task automatic expect_msg(input int port, input int src, input logic [7:0] id, input string tag);
        exp_t e;
        e.port = port; e.id = id; e.data = dat(src, id); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop expectations, compare the presented message, then read it.
    task automatic drain();
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " valid"}, 64'(rx_valid[e.port]), 64'd1);
            chk({e.tag, " id"},    64'(rx_id[e.port*8 +: 8]), 64'(e.id));
            chk({e.tag, " data"},  64'(rx_data[e.port*32 +: 32]), 64'(e.data));
            rx_rd[e.port] = 1'b1;
            tick();
            rx_rd[e.port] = 1'b0;
        end
    endtask

    task automatic clear_all();
        st_clr_avail = '1;
        st_clr_drop = '1;
        tick();
        st_clr_avail = '0;
        st_clr_drop = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk("R10 tx_pending", 64'(tx_pending), 64'd0);
        chk("R10 rx_valid", 64'(rx_valid), 64'd0);
        chk("R10 st_avail", 64'(st_avail), 64'd0);
        chk("R10 st_drop", 64'(st_drop), 64'd0);

        // R1 R2 R3: fan-out on one edge, own port excluded
        publish(0, 8'h12);
        chk("R2 same-edge fan-out", 64'(rx_valid), 64'b1010);
        chk("R8 avail set", 64'(st_avail), 64'b1010);
        expect_msg(1, 0, 8'h12, "R1 p1");
        expect_msg(3, 0, 8'h12, "R2 p3");
        drain();
        chk("R3 no self copy", 64'(rx_valid), 64'd0);
        st_clr_avail = 4'b0010;
        tick();
        st_clr_avail = '0;
        chk("R8 selective clear", 64'(st_avail), 64'b1000);
        clear_all();

        // R4 priority read
        publish(2, 8'h30);
        publish(2, 8'h15);
        publish(2, 8'h1A);
        expect_msg(0, 2, 8'h15, "R4 p0 first");
        expect_msg(0, 2, 8'h1A, "R4 p0 second");
        expect_msg(0, 2, 8'h30, "R4 p0 third");
        expect_msg(1, 2, 8'h15, "R1 p1 a");
        expect_msg(1, 2, 8'h1A, "R1 p1 b");
        expect_msg(3, 2, 8'h15, "R4 p3 a");
        expect_msg(3, 2, 8'h1A, "R4 p3 b");
        expect_msg(3, 2, 8'h30, "R4 p3 c");
        drain();
        chk("R4 empty", 64'(rx_valid), 64'd0);
        chk("R5 no drops", 64'(st_drop), 64'd0);
        clear_all();

        // R5 drop policy on p1, R6 overwrite on p3
        publish(0, 8'h18);
        publish(0, 8'h11);
        publish(0, 8'h1F);
        publish(0, 8'h10);
        chk("R5 R6 drop flags", 64'(st_drop), 64'b1010);
        expect_msg(1, 0, 8'h11, "R5 p1 a");
        expect_msg(1, 0, 8'h18, "R5 p1 b");
        expect_msg(1, 0, 8'h1F, "R5 p1 c");
        expect_msg(3, 0, 8'h10, "R6 p3 a");
        expect_msg(3, 0, 8'h11, "R6 p3 b");
        expect_msg(3, 0, 8'h18, "R6 p3 c");
        drain();
        chk("R5 empty", 64'(rx_valid), 64'd0);
        st_clr_drop = 4'b0010;
        tick();
        st_clr_drop = '0;
        chk("R8 drop clear one", 64'(st_drop), 64'b1000);
        clear_all();

        // R6 no replace when arrival is weaker; R5 on p0
        publish(1, 8'h05);
        publish(1, 8'h06);
        publish(1, 8'h07);
        publish(1, 8'h40);
        chk("R6 weaker discarded flag", 64'(st_drop), 64'b1001);
        expect_msg(0, 1, 8'h05, "R5 p0 a");
        expect_msg(0, 1, 8'h06, "R5 p0 b");
        expect_msg(0, 1, 8'h07, "R5 p0 c");
        expect_msg(3, 1, 8'h05, "R6 p3 a");
        expect_msg(3, 1, 8'h06, "R6 p3 b");
        expect_msg(3, 1, 8'h07, "R6 p3 c");
        drain();
        chk("R6 empty", 64'(rx_valid), 64'd0);
        clear_all();

        // R7 arbitration and ignored write while pending
        tx_wr = 4'b1110;
        tx_id[8 +: 8] = 8'h22;  tx_data[32 +: 32] = dat(1, 8'h22);
        tx_id[16 +: 8] = 8'h21; tx_data[64 +: 32] = dat(2, 8'h21);
        tx_id[24 +: 8] = 8'h23; tx_data[96 +: 32] = dat(3, 8'h23);
        tick();
        chk("R7 all pending", 64'(tx_pending), 64'b1110);
        tx_wr = 4'b1000;
        tx_id[24 +: 8] = 8'h02; tx_data[96 +: 32] = dat(3, 8'h02);
        tick();
        tx_wr = '0;
        chk("R7 low index first", 64'(tx_pending), 64'b1100);
        chk("R7 first on bus", 64'(rx_id[7:0]), 64'h22);
        tick();
        chk("R7 next pending", 64'(tx_pending), 64'b1000);
        tick();
        chk("R7 all sent", 64'(tx_pending), 64'd0);
        expect_msg(0, 2, 8'h21, "R7 p0 a");
        expect_msg(0, 1, 8'h22, "R7 p0 b");
        expect_msg(0, 3, 8'h23, "R7 p0 c");
        expect_msg(3, 2, 8'h21, "R7 p3 a");
        expect_msg(3, 1, 8'h22, "R7 p3 b");
        drain();
        chk("R7 ignored write absent", 64'(rx_valid), 64'd0);
        clear_all();

        // R1 exact-match filter
        publish(0, 8'h25);
        publish(0, 8'h24);
        chk("R1 exact filter", 64'(rx_valid), 64'b1100);
        expect_msg(2, 0, 8'h25, "R1 p2 exact");
        expect_msg(3, 0, 8'h24, "R1 p3 a");
        expect_msg(3, 0, 8'h25, "R1 p3 b");
        drain();
        chk("R1 empty", 64'(rx_valid), 64'd0);
        clear_all();

        // R9 read and arrival on a full store in the same edge
        publish(1, 8'h31);
        publish(1, 8'h32);
        publish(1, 8'h33);
        tx_wr[1] = 1'b1;
        tx_id[8 +: 8] = 8'h34; tx_data[32 +: 32] = dat(1, 8'h34);
        tick();
        tx_wr[1] = 1'b0;
        chk("R4 head before R9", 64'(rx_id[7:0]), 64'h31);
        rx_rd[0] = 1'b1;
        tick();
        rx_rd[0] = 1'b0;
        chk("R9 no loss on p0", 64'(st_drop[0]), 64'd0);
        chk("R6 p3 weaker lost", 64'(st_drop[3]), 64'd1);
        expect_msg(0, 1, 8'h32, "R9 p0 a");
        expect_msg(0, 1, 8'h33, "R9 p0 b");
        expect_msg(0, 1, 8'h34, "R9 p0 c");
        expect_msg(3, 1, 8'h31, "R6 p3 a");
        expect_msg(3, 1, 8'h32, "R6 p3 b");
        expect_msg(3, 1, 8'h33, "R6 p3 c");
        drain();
        chk("R9 empty", 64'(rx_valid), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule